// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer Bank

This block is a register-mapped bank of independent down counters. Each channel counts on a one-cycle tick pulse. The pulse is taken from one of four tick-enable inputs and then thinned by a power-of-two prescaler. When a channel runs out, its bit in a shared pending register is set. An interrupt line is raised whenever a pending bit meets its matching enable bit. A channel either wraps back to its interval and keeps running, or stops at zero and turns itself off.

Software reaches everything through a plain 32-bit port: one address bus, a write strobe with write data, and read data that follows the address combinationally. A separate slow-clock selection register holds two control bits, which drive output pins. Any write to it must carry a 16-bit key in its upper half, and a write with the wrong key is dropped. A channel loaded with an all-ones interval becomes a free-running counter. Software reads that counter and inverts the value to get an up-count.

Top module: `dtimer_top`

## Requirements
- R1: After reset every readable register (enable, pending, each channel's control, interval and current value, slow-clock register) reads zero and `irq` is low.
- R2: The enable register at offset 0x00 holds one bit per channel (bit n = channel n); bits above NUM_CH-1 read zero; `irq` is high exactly when some channel has both its pending and enable bits set.
- R3: Channel n uses offset 0x10+0x10*n for control, +0x4 for interval and +0x8 for current value; writing control with bit 1 set loads the interval into the current value one cycle later, and bit 1 always reads zero.
- R4: Control bit 0 enables the channel and bits 3:2 pick which `srcTick` input drives it; an enabled channel lowers its current value by one per effective tick, and ticks on unselected inputs change nothing; with an all-ones interval, the inverted current value equals the number of ticks seen.
- R5: Control bits 6:4 hold a prescale value p; an effective tick happens on every 2^p-th selected source tick, counted from when the channel is enabled.
- R6: With control bit 7 clear (continuous), an effective tick that finds the current value at 1 or 0 sets the channel's pending bit and reloads the current value from the interval.
- R7: With control bit 7 set (single-shot), such a tick sets the pending bit, leaves the current value at zero and clears control bit 0, so further ticks change nothing.
- R8: The pending register at offset 0x04 is set on expiry whether or not the channel's enable bit is set; writing a one to a bit clears it, and writing a zero leaves it unchanged.
- R9: The slow-clock register at offset 0x100 updates bit 0 (`slowSel`) and bit 14 (`slowAutoSwitch`) only when write data bits 31:16 equal 0x16AA; otherwise it keeps its value, and bits 31:16 always read zero.
- R10: Writes to a current-value register are ignored, and writing the interval does not change the current value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| regAddr | input | ADDR_W | Byte address for reads and writes |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for `regAddr`, combinational |
| srcTick | input | 4 | Tick-enable pulses, one per clock source |
| irq | output | 1 | OR of pending AND enable over all channels |
| slowSel | output | 1 | Slow-clock source select bit |
| slowAutoSwitch | output | 1 | Slow-clock automatic switching bit |

## Verification
The bench builds the block with NUM_CH = 3, so the last channel sits at 0x30. With that build, an enable write of 0xFF shows the masking of bits above the channel count. The three channels are set up to cover continuous mode with no prescale, single-shot mode with a divide-by-four prescale, and a free-running all-ones counter. Each channel listens to its own or a shared tick input, which shows that an unselected source has no effect. The 32-bit counter width is kept, so the all-ones interval and its inverted read-back are exercised at full width.

// File: rtl/dtimer_pkg.sv
`timescale 1ns/1ps
package dtimer_pkg;
  localparam int WORD_W   = 32;
  localparam int CH_IDX_W = 4;
  localparam int SRC_W    = 2;
  localparam int PRE_W    = 3;
  localparam int NUM_SRC  = 2 ** SRC_W;
  localparam int SLOW_OFF = 256;
  localparam logic [15:0] SLOW_KEY = 16'h16AA;

  // Per-channel control word, bit 0 at the bottom.
  typedef struct packed {
    logic             mode;    // 1 = single-shot
    logic [PRE_W-1:0] pre;     // divide by 2^pre
    logic [SRC_W-1:0] src;     // tick input index
    logic             reload;  // self-clearing load request
    logic             en;
  } chctl_t;

  // Strobes from register decode to the datapath.
  typedef struct packed {
    logic                pendClr;
    logic                chCtrlWr;
    logic                chIntvWr;
    logic [CH_IDX_W-1:0] chIdx;
    logic [WORD_W-1:0]   data;
  } strobe_t;
endpackage

// File: rtl/dtimer_chan.sv
`timescale 1ns/1ps
module dtimer_chan
  import dtimer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctrlWr,
  input  logic               intvWr,
  input  logic [CNT_W-1:0]   wrData,
  input  logic [NUM_SRC-1:0] srcTick,
  output chctl_t             ctlOut,
  output logic [CNT_W-1:0]   intvOut,
  output logic [CNT_W-1:0]   cntOut,
  output logic               expire
);
  localparam int PCNT_W = (2 ** PRE_W) - 1;

  chctl_t            ctl;
  logic [CNT_W-1:0]  intv;
  logic [CNT_W-1:0]  cnt;
  logic [PCNT_W-1:0] preCnt;
  logic [PCNT_W-1:0] preMask;
  logic              srcHit;
  logic              effTick;
  logic              atEnd;

  always_comb begin
    srcHit  = srcTick[ctl.src];
    preMask = PCNT_W'((8'd1 << ctl.pre) - 8'd1);
    effTick = ctl.en & srcHit & ((preCnt & preMask) == preMask);
    atEnd   = (cnt <= CNT_W'(1));
    expire  = effTick & ~ctl.reload & atEnd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl    <= '0;
      intv   <= '0;
      cnt    <= '0;
      preCnt <= '0;
    end else begin
      if (intvWr) intv <= wrData;

      if (ctrlWr) begin
        ctl <= chctl_t'(wrData[7:0]);
      end else begin
        ctl.reload <= 1'b0;
        if (expire && ctl.mode) ctl.en <= 1'b0;
      end

      if (ctl.reload) begin
        cnt <= intv;
      end else if (effTick) begin
        if (atEnd) cnt <= ctl.mode ? '0 : intv;
        else       cnt <= cnt - CNT_W'(1);
      end

      if (!ctl.en)     preCnt <= '0;
      else if (srcHit) preCnt <= preCnt + PCNT_W'(1);
    end
  end

  always_comb begin
    ctlOut        = ctl;
    ctlOut.reload = 1'b0;
  end
  assign intvOut = intv;
  assign cntOut  = cnt;

  AST_RELOAD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.reload |=> (cnt == $past(intv)));  // R3
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (effTick && !ctl.reload && !atEnd) |=> (cnt == $past(cnt) - CNT_W'(1)));  // R4
  AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !ctl.mode) |=> (cnt == $past(intv)));  // R6
  AST_ONESHOT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && ctl.mode && !ctrlWr) |=> (!ctl.en && cnt == '0));  // R7
endmodule

// File: rtl/dtimer_datapath.sv
`timescale 1ns/1ps
module dtimer_datapath
  import dtimer_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  strobe_t                       stb,
  input  logic [NUM_SRC-1:0]            srcTick,
  output chctl_t [NUM_CH-1:0]           chCtl,
  output logic   [NUM_CH-1:0][CNT_W-1:0] chIntv,
  output logic   [NUM_CH-1:0][CNT_W-1:0] chCnt,
  output logic   [NUM_CH-1:0]           pend
);
  logic [NUM_CH-1:0] expireVec;
  logic [NUM_CH-1:0] clrMask;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    logic ctrlHit;
    logic intvHit;
    assign ctrlHit = stb.chCtrlWr && (stb.chIdx == CH_IDX_W'(g));
    assign intvHit = stb.chIntvWr && (stb.chIdx == CH_IDX_W'(g));

    dtimer_chan #(.CNT_W(CNT_W)) chan_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .ctrlWr  (ctrlHit),
      .intvWr  (intvHit),
      .wrData  (stb.data[CNT_W-1:0]),
      .srcTick (srcTick),
      .ctlOut  (chCtl[g]),
      .intvOut (chIntv[g]),
      .cntOut  (chCnt[g]),
      .expire  (expireVec[g])
    );
  end

  assign clrMask = stb.pendClr ? stb.data[NUM_CH-1:0] : '0;

  // A new expiry wins over a clear in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~clrMask) | expireVec;
  end

  AST_PEND_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (expireVec != '0) |=> ((pend & $past(expireVec)) == $past(expireVec)));  // R8
  AST_PEND_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.pendClr && expireVec == '0) |=> ((pend & $past(clrMask)) == '0));  // R8
endmodule

// File: rtl/dtimer_ctrl.sv
`timescale 1ns/1ps
module dtimer_ctrl
  import dtimer_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 12
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [ADDR_W-1:0]              regAddr,
  input  logic                           regWrEn,
  input  logic [WORD_W-1:0]              regWrData,
  output logic [WORD_W-1:0]              regRdData,
  input  chctl_t [NUM_CH-1:0]            chCtl,
  input  logic   [NUM_CH-1:0][CNT_W-1:0] chIntv,
  input  logic   [NUM_CH-1:0][CNT_W-1:0] chCnt,
  input  logic   [NUM_CH-1:0]            pend,
  output strobe_t                        stb,
  output logic   [NUM_CH-1:0]            ienReg,
  output logic                           slowSel,
  output logic                           slowAuto
);
  logic                inLow;
  logic                isSlow;
  logic [3:0]          blk;
  logic [1:0]          sub;
  logic                chHit;
  logic [CH_IDX_W-1:0] chIdx;
  logic                ienWr;
  logic                slowWr;
  logic                keyOk;

  always_comb begin
    inLow  = (regAddr[ADDR_W-1:8] == '0) && (regAddr[1:0] == 2'b00);
    isSlow = (regAddr == ADDR_W'(SLOW_OFF));
    blk    = regAddr[7:4];
    sub    = regAddr[3:2];
    chHit  = inLow && (blk != 4'd0) && (int'(blk) <= NUM_CH);
    chIdx  = CH_IDX_W'(blk - 4'd1);
    keyOk  = (regWrData[31:16] == SLOW_KEY);
    ienWr  = regWrEn && inLow && (blk == 4'd0) && (sub == 2'd0);
    slowWr = regWrEn && isSlow;

    stb.pendClr  = regWrEn && inLow && (blk == 4'd0) && (sub == 2'd1);
    stb.chCtrlWr = regWrEn && chHit && (sub == 2'd0);
    stb.chIntvWr = regWrEn && chHit && (sub == 2'd1);
    stb.chIdx    = chIdx;
    stb.data     = regWrData;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ienReg   <= '0;
      slowSel  <= 1'b0;
      slowAuto <= 1'b0;
    end else begin
      if (ienWr) ienReg <= regWrData[NUM_CH-1:0];
      if (slowWr && keyOk) begin
        slowSel  <= regWrData[0];
        slowAuto <= regWrData[14];
      end
    end
  end

  always_comb begin
    regRdData = '0;
    if (isSlow) begin
      regRdData = {16'h0000, 1'b0, slowAuto, 13'h0000, slowSel};
    end else if (inLow && blk == 4'd0) begin
      if (sub == 2'd0)      regRdData = WORD_W'(ienReg);
      else if (sub == 2'd1) regRdData = WORD_W'(pend);
    end else if (chHit) begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (chIdx == CH_IDX_W'(i)) begin
          case (sub)
            2'd0:    regRdData = WORD_W'(chCtl[i]);
            2'd1:    regRdData = WORD_W'(chIntv[i]);
            2'd2:    regRdData = WORD_W'(chCnt[i]);
            default: regRdData = '0;
          endcase
        end
      end
    end
  end

  AST_KEY_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (slowWr && !keyOk) |=> ($stable(slowSel) && $stable(slowAuto)));  // R9
  AST_IEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ienWr |=> $stable(ienReg));  // R2
endmodule

// File: rtl/dtimer_top.sv
`timescale 1ns/1ps
module dtimer_top
  import dtimer_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regWrEn,
  input  logic [WORD_W-1:0]  regWrData,
  output logic [WORD_W-1:0]  regRdData,
  input  logic [NUM_SRC-1:0] srcTick,
  output logic               irq,
  output logic               slowSel,
  output logic               slowAutoSwitch
);
  strobe_t                       stb;
  chctl_t [NUM_CH-1:0]           chCtl;
  logic   [NUM_CH-1:0][CNT_W-1:0] chIntv;
  logic   [NUM_CH-1:0][CNT_W-1:0] chCnt;
  logic   [NUM_CH-1:0]           pend;
  logic   [NUM_CH-1:0]           ienReg;

  dtimer_ctrl #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .regAddr   (regAddr),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .chCtl     (chCtl),
    .chIntv    (chIntv),
    .chCnt     (chCnt),
    .pend      (pend),
    .stb       (stb),
    .ienReg    (ienReg),
    .slowSel   (slowSel),
    .slowAuto  (slowAutoSwitch)
  );

  dtimer_datapath #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) dp_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .stb     (stb),
    .srcTick (srcTick),
    .chCtl   (chCtl),
    .chIntv  (chIntv),
    .chCnt   (chCnt),
    .pend    (pend)
  );

  assign irq = |(pend & ienReg);

  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (pend != '0 && ienReg != '0));  // R2
endmodule

// File: tb/dtimer_top_tb_top.sv
`timescale 1ns/1ps
module dtimer_top_tb_top;
  localparam int NCH = 3;

  typedef struct {
    logic [11:0] addr;
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [3:0]  srcTick = '0;
  logic        irq;
  logic        slowSel;
  logic        slowAutoSwitch;

  int    nChecks = 0;
  int    nErrors = 0;
  bit    done = 1'b0;
  item_t sbq[$];

  always #4 clk = ~clk;  // 125 MHz

  dtimer_top #(.NUM_CH(NCH), .CNT_W(32), .ADDR_W(12)) dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .regAddr        (regAddr),
    .regWrEn        (regWrEn),
    .regWrData      (regWrData),
    .regRdData      (regRdData),
    .srcTick        (srcTick),
    .irq            (irq),
    .slowSel        (slowSel),
    .slowAutoSwitch (slowAutoSwitch)
  );

  function automatic void check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endfunction

  // Monitor: pops expected reads and compares away from the active edge.
  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      check(it.tag, regRdData, it.exp);
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(posedge clk); #1;
    regWrEn = 1'b0;
  endtask

  // Driver: pushes an expected read value and lets the monitor compare it.
  task automatic expRd(input logic [11:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(posedge clk); #1;
    regAddr = a;
    it.addr = a; it.exp = e; it.tag = tag;
    sbq.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic pulse(input int src, input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
      srcTick[src] = 1'b1;
      @(posedge clk); #1;
      srcTick[src] = 1'b0;
    end
  endtask

  task automatic chkPin(input string tag, input logic act, input logic exp);
    @(negedge clk);
    check(tag, {31'b0, act}, {31'b0, exp});
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nErrors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    expRd(12'h000, 32'h0, "R1 ien");
    expRd(12'h004, 32'h0, "R1 pend");
    expRd(12'h010, 32'h0, "R1 ctrl0");
    expRd(12'h014, 32'h0, "R1 intv0");
    expRd(12'h018, 32'h0, "R1 cnt0");
    expRd(12'h100, 32'h0, "R1 slow");
    chkPin("R1 irq", irq, 1'b0);

    // R2: enable mask width
    wr(12'h000, 32'hFF);
    expRd(12'h000, 32'h7, "R2 ien masked");
    wr(12'h000, 32'h0);

    // R10 / R3: interval write leaves count, reload copies it
    wr(12'h014, 32'd5);
    expRd(12'h018, 32'd0, "R10 intv write keeps cnt");
    wr(12'h010, 32'h2);
    expRd(12'h018, 32'd5, "R3 reload copy");
    expRd(12'h010, 32'h0, "R3 reload reads zero");
    wr(12'h018, 32'h1234);
    expRd(12'h018, 32'd5, "R10 cnt write ignored");

    // R4: continuous, src 1, no prescale
    wr(12'h010, 32'h5);
    expRd(12'h010, 32'h5, "R4 ctrl readback");
    pulse(1, 2);
    expRd(12'h018, 32'd3, "R4 two ticks");
    pulse(0, 2);
    expRd(12'h018, 32'd3, "R4 unselected src");
    pulse(1, 2);
    expRd(12'h018, 32'd1, "R4 at one");
    pulse(1, 1);
    expRd(12'h018, 32'd5, "R6 wrap reload");
    expRd(12'h004, 32'h1, "R8 pend set while disabled");
    chkPin("R2 irq masked", irq, 1'b0);

    // R2 / R8: enable and clear
    wr(12'h000, 32'h1);
    chkPin("R2 irq raised", irq, 1'b1);
    wr(12'h004, 32'h0);
    expRd(12'h004, 32'h1, "R8 zero write keeps");
    wr(12'h004, 32'h1);
    expRd(12'h004, 32'h0, "R8 one clears");
    chkPin("R2 irq dropped", irq, 1'b0);
    wr(12'h010, 32'h0);

    // R5 / R7: channel 1, single-shot, src 2, prescale 2
    wr(12'h024, 32'd3);
    wr(12'h020, 32'h2);
    expRd(12'h028, 32'd3, "R3 ch1 reload");
    wr(12'h020, 32'hA9);
    pulse(2, 3);
    expRd(12'h028, 32'd3, "R5 no tick before 4th");
    pulse(2, 1);
    expRd(12'h028, 32'd2, "R5 4th source tick");
    pulse(2, 4);
    expRd(12'h028, 32'd1, "R5 next 4");
    pulse(2, 4);
    expRd(12'h028, 32'd0, "R7 stops at zero");
    expRd(12'h020, 32'hA8, "R7 enable cleared");
    expRd(12'h004, 32'h2, "R8 ch1 pend");
    chkPin("R2 irq ch1 not enabled", irq, 1'b0);
    pulse(2, 4);
    expRd(12'h028, 32'd0, "R7 stays zero");

    // R4: free-running all-ones on channel 2
    wr(12'h034, 32'hFFFF_FFFF);
    wr(12'h030, 32'h2);
    wr(12'h030, 32'h5);
    pulse(1, 3);
    expRd(12'h038, 32'hFFFF_FFFC, "R4 free-run value");
    @(posedge clk); #1;
    regAddr = 12'h038;
    @(negedge clk);
    check("R4 inverted up-count", ~regRdData, 32'd3);

    // R9: key-protected slow register
    wr(12'h100, 32'h16AA_4001);
    expRd(12'h100, 32'h0000_4001, "R9 keyed write");
    chkPin("R9 sel pin", slowSel, 1'b1);
    chkPin("R9 auto pin", slowAutoSwitch, 1'b1);
    wr(12'h100, 32'h1234_0000);
    expRd(12'h100, 32'h0000_4001, "R9 bad key ignored");
    wr(12'h100, 32'h16AA_0000);
    expRd(12'h100, 32'h0, "R9 keyed clear");

    repeat (2) @(posedge clk);
    done = 1'b1;
    finishRun();
  end
endmodule